// File: doc/BRIEF.md
# Serial Power-Up Configuration Loader

This block reads a fixed-length configuration bitstream during the power-up phase. It shifts the bits in one at a time from a slow external source, such as a serial memory or a small sequencer. The block makes its own strobe clock by dividing the system clock by a power of two. It sends this clock out so that the source can advance one bit per period. Shifting starts once the synchronized reset is released. After the last bit has been captured, the block raises a completion flag and stops the strobe clock.

With the stream captured, the block decodes fixed bit positions into processor operating fields:
- write data pattern code
- core clock multiplier
- byte order
- non-block write policy
- timer interrupt enable
- bus width
- output drive strength in percent
- address-to-data delay
- fast-multiply enable

A single error output goes high when any reserved bit is set or any reserved code is selected. The stream is kept unchanged until the next reset, so the decoded fields remain stable for the rest of operation.

Top module: `boot_mode_loader`

## Requirements
- R1: `mode_clk` starts low after reset release and has a period of exactly CLK_DIV system clocks, high for the last CLK_DIV/2 clocks of each period. Once `done` is high, it stays low.
- R2: `serial_in` is sampled once per period, on the clock where `mode_clk` falls. The first sample is stream bit 0 and the k-th sample is stream bit k-1.
- R3: `done` is low during reset. It rises on the same clock as the falling `mode_clk` edge that ends the STREAM_LEN-th period, and it stays high until reset.
- R4: After `done` rises, later activity on `serial_in` changes no decoded output and does not change `mode_error`.
- R5: `pattern_code` equals stream bits 4..1, with bit 4 as the MSB. Codes 9 to 15 set `mode_error`.
- R6: Stream bits 7..5 (bit 7 as the MSB) hold a ratio code c. Codes 0 to 6 give `clk_mult` = c+2. Code 7 gives `clk_mult` = 0 and sets `mode_error`.
- R7: `big_endian` equals stream bit 8 (1 = big endian). `bus_32` equals stream bit 12 (1 = 32-bit bus, 0 = 64-bit bus).
- R8: `wr_mode` equals {bit 10, bit 9}, with the following encoding. Code 01 sets `mode_error`.

| `wr_mode` | Meaning |
|---|---|
| 00 | legacy |
| 10 | pipelined |
| 11 | reissue |
| 01 | reserved |

- R9: `timer_irq_en` is the inverse of stream bit 11. `fast_mult_en` is the inverse of stream bit 19.
- R10: `drive_pct` is set by {bit 14, bit 13} as follows.

| {bit 14, bit 13} | `drive_pct` |
|---|---|
| 10 | 100 |
| 11 | 83 |
| 00 | 67 |
| 01 | 50 |

- R11: `addr_data_dly` equals stream bits 17..15, with bit 17 as the MSB.
- R12: `mode_error` is low while `done` is low. Once `done` is high, `mode_error` is high if and only if one of these holds: any of stream bits 0, 18, or 20 through STREAM_LEN-1 is 1, or a reserved code from R5, R6 or R8 is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Configuration bitstream input |
| mode_clk | output | 1 | Divided strobe clock to the bit source |
| done | output | 1 | Whole stream captured |
| pattern_code | output | 4 | Write data pattern code |
| clk_mult | output | 4 | Core clock multiplier (0 when reserved) |
| big_endian | output | 1 | Byte order select |
| wr_mode | output | 2 | Non-block write policy |
| timer_irq_en | output | 1 | Timer interrupt enable |
| bus_32 | output | 1 | Narrow bus select |
| drive_pct | output | 7 | Output drive strength in percent |
| addr_data_dly | output | 3 | Address-to-data delay in system clocks |
| fast_mult_en | output | 1 | Fast multiply enable |
| mode_error | output | 1 | Reserved bit or code detected |

## Verification
The assertions assume the following about the environment:
- CLK_DIV is a power of two, at least 2.
- STREAM_LEN is at least 27.
- Reset is held for at least one clock.
- The bit source changes `serial_in` only after a falling `mode_clk` edge.

The bench respects these limits by using CLK_DIV=4 and STREAM_LEN=32. It drives each new bit on the falling system clock edge after `mode_clk` falls, and it releases reset only when `mode_clk` is low. It toggles `serial_in` only after `done` is high, which is exactly when the frozen-output rule applies.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  // Stream positions of the decoded fields (the external source defines these)
  localparam int PAT_LSB   = 1;
  localparam int PAT_W     = 4;
  localparam int RAT_LSB   = 5;
  localparam int RAT_W     = 3;
  localparam int END_BIT   = 8;
  localparam int WM_LSB    = 9;
  localparam int TMR_BIT   = 11;
  localparam int BUS_BIT   = 12;
  localparam int DRV_LSB   = 13;
  localparam int DLY_LSB   = 15;
  localparam int DLY_W     = 3;
  localparam int RSV_A_BIT = 0;
  localparam int RSV_B_BIT = 18;
  localparam int FMUL_BIT  = 19;
  localparam int RSV_HI    = 20;
  localparam int MIN_LEN   = 27;

  localparam logic [3:0] PAT_MAX  = 4'd8;
  localparam logic [2:0] RAT_RSVD = 3'd7;

  typedef enum logic [1:0] {
    WM_LEGACY  = 2'b00,
    WM_RSVD    = 2'b01,
    WM_PIPE    = 2'b10,
    WM_REISSUE = 2'b11
  } wr_mode_e;

  typedef struct packed {
    logic [3:0] pattern;
    logic [3:0] mult;
    logic       big_endian;
    wr_mode_e   wr_mode;
    logic       timer_en;
    logic       bus32;
    logic [6:0] drive_pct;
    logic [2:0] dly;
    logic       fast_mul;
  } mode_fields_t;

endpackage

// File: rtl/mode_clk_div.sv
module mode_clk_div #(
  parameter int CLK_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic mode_clk
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick     = run && (cnt_q == LAST);
  assign mode_clk = cnt_q[CW-1];

endmodule

// File: rtl/mode_shift_capture.sv
module mode_shift_capture #(
  parameter int STREAM_LEN = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  serial_in,
  output logic [STREAM_LEN-1:0] stream,
  output logic                  done
);
  localparam int NW = $clog2(STREAM_LEN + 1);
  localparam logic [NW-1:0] LAST_IDX = NW'(STREAM_LEN - 1);

  logic [STREAM_LEN-1:0] sr_q, sr_d;
  logic [NW-1:0]         n_q, n_d;
  logic                  done_q, done_d;
  logic                  shift_en;

  assign shift_en = tick && !done_q;

  always_comb begin
    sr_d   = {serial_in, sr_q[STREAM_LEN-1:1]};
    n_d    = n_q + 1'b1;
    done_d = (n_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
    end else if (shift_en) begin
      sr_q   <= sr_d;
      n_q    <= n_d;
      done_q <= done_d;
    end
  end

  assign stream = sr_q;
  assign done   = done_q;

endmodule

// File: rtl/mode_field_decode.sv
module mode_field_decode
  import boot_mode_pkg::*;
#(
  parameter int STREAM_LEN = 256
) (
  input  logic [STREAM_LEN-1:0] stream,
  output mode_fields_t          fields,
  output logic                  illegal
);
  logic [PAT_W-1:0] pat;
  logic [RAT_W-1:0] ratio;
  logic [1:0]       wm;
  logic [1:0]       drv;
  logic             rsvd_set;

  always_comb begin
    pat   = stream[PAT_LSB +: PAT_W];
    ratio = stream[RAT_LSB +: RAT_W];
    wm    = stream[WM_LSB +: 2];
    drv   = stream[DRV_LSB +: 2];

    fields.pattern    = pat;
    fields.mult       = (ratio == RAT_RSVD) ? 4'd0 : ({1'b0, ratio} + 4'd2);
    fields.big_endian = stream[END_BIT];
    fields.wr_mode    = wr_mode_e'(wm);
    fields.timer_en   = !stream[TMR_BIT];
    fields.bus32      = stream[BUS_BIT];
    fields.dly        = stream[DLY_LSB +: DLY_W];
    fields.fast_mul   = !stream[FMUL_BIT];

    unique case (drv)
      2'b10:   fields.drive_pct = 7'd100;
      2'b11:   fields.drive_pct = 7'd83;
      2'b00:   fields.drive_pct = 7'd67;
      default: fields.drive_pct = 7'd50;
    endcase

    rsvd_set = stream[RSV_A_BIT] | stream[RSV_B_BIT] |
               (|stream[STREAM_LEN-1:RSV_HI]);
    illegal  = rsvd_set | (pat > PAT_MAX) | (ratio == RAT_RSVD) |
               (wm == WM_RSVD);
  end

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int STREAM_LEN = 256,
  parameter int CLK_DIV    = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_in,
  output logic       mode_clk,
  output logic       done,
  output logic [3:0] pattern_code,
  output logic [3:0] clk_mult,
  output logic       big_endian,
  output logic [1:0] wr_mode,
  output logic       timer_irq_en,
  output logic       bus_32,
  output logic [6:0] drive_pct,
  output logic [2:0] addr_data_dly,
  output logic       fast_mult_en,
  output logic       mode_error
);
  logic [1:0]            rst_sync_q;
  logic                  live;
  logic                  tick;
  logic                  run;
  logic [STREAM_LEN-1:0] stream;
  mode_fields_t          fields;
  logic                  illegal;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign live = rst_sync_q[1];
  assign run  = live && !done;

  mode_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .mode_clk (mode_clk)
  );

  mode_shift_capture #(.STREAM_LEN(STREAM_LEN)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .serial_in (serial_in),
    .stream    (stream),
    .done      (done)
  );

  mode_field_decode #(.STREAM_LEN(STREAM_LEN)) u_dec (
    .stream  (stream),
    .fields  (fields),
    .illegal (illegal)
  );

  assign pattern_code  = fields.pattern;
  assign clk_mult      = fields.mult;
  assign big_endian    = fields.big_endian;
  assign wr_mode       = fields.wr_mode;
  assign timer_irq_en  = fields.timer_en;
  assign bus_32        = fields.bus32;
  assign drive_pct     = fields.drive_pct;
  assign addr_data_dly = fields.dly;
  assign fast_mult_en  = fields.fast_mul;
  assign mode_error    = done && illegal;

endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_clk,
  input logic       done,
  input logic [3:0] pattern_code,
  input logic [3:0] clk_mult,
  input logic       big_endian,
  input logic [1:0] wr_mode,
  input logic       timer_irq_en,
  input logic       bus_32,
  input logic [6:0] drive_pct,
  input logic [2:0] addr_data_dly,
  input logic       fast_mult_en,
  input logic       mode_error
);
  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R3
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(mode_clk));

  // R1
  mclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mode_clk);

  // R4
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({pattern_code, clk_mult, big_endian, wr_mode, timer_irq_en,
                      bus_32, drive_pct, addr_data_dly, fast_mult_en, mode_error}));

  // R12
  err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !mode_error);

  // R6
  mult_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clk_mult == 4'd0) |-> mode_error);

  // R8
  wm_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_mode == 2'b01) |-> mode_error);

  // R10
  drive_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (drive_pct == 7'd100 || drive_pct == 7'd83 ||
              drive_pct == 7'd67  || drive_pct == 7'd50));
endmodule

bind boot_mode_loader boot_mode_loader_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_clk      (mode_clk),
  .done          (done),
  .pattern_code  (pattern_code),
  .clk_mult      (clk_mult),
  .big_endian    (big_endian),
  .wr_mode       (wr_mode),
  .timer_irq_en  (timer_irq_en),
  .bus_32        (bus_32),
  .drive_pct     (drive_pct),
  .addr_data_dly (addr_data_dly),
  .fast_mult_en  (fast_mult_en),
  .mode_error    (mode_error)
);

// File: tb/tb_boot_mode_loader.sv
`timescale 1ns/1ps
module tb_boot_mode_loader;
  localparam int LEN = 32;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serial_in = 1'b0;
  logic mode_clk, done, big_endian, timer_irq_en, bus_32, fast_mult_en, mode_error;
  logic [3:0] pattern_code, clk_mult;
  logic [1:0] wr_mode;
  logic [6:0] drive_pct;
  logic [2:0] addr_data_dly;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_rise = 0;
  int per_meas = 0;
  int hi_meas = 0;
  logic mclk_prev = 1'b0;

  always #10 clk = ~clk;

  boot_mode_loader #(.STREAM_LEN(LEN), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .mode_clk(mode_clk),
    .done(done), .pattern_code(pattern_code), .clk_mult(clk_mult),
    .big_endian(big_endian), .wr_mode(wr_mode), .timer_irq_en(timer_irq_en),
    .bus_32(bus_32), .drive_pct(drive_pct), .addr_data_dly(addr_data_dly),
    .fast_mult_en(fast_mult_en), .mode_error(mode_error)
  );

  // mode clock period / high-time monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mode_clk && !mclk_prev) begin
      per_meas  = cyc - last_rise;
      last_rise = cyc;
    end
    if (!mode_clk && mclk_prev) hi_meas = cyc - last_rise;
    mclk_prev = mode_clk;
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic [LEN-1:0] mk(input int pat, input int ratio, input int en,
      input int wm, input int b11, input int b12, input int drv, input int dly,
      input int b19);
    logic [LEN-1:0] s = '0;
    s[4:1]   = pat[3:0];
    s[7:5]   = ratio[2:0];
    s[8]     = en[0];
    s[10:9]  = wm[1:0];
    s[11]    = b11[0];
    s[12]    = b12[0];
    s[14:13] = drv[1:0];
    s[17:15] = dly[2:0];
    s[19]    = b19[0];
    return s;
  endfunction

  function automatic int exp_drive(input int code);
    case (code)
      2: return 100;
      3: return 83;
      0: return 67;
      default: return 50;
    endcase
  endfunction

  task automatic check_fields(input logic [LEN-1:0] s);
    int ratio = int'(s[7:5]);
    int wm = int'(s[10:9]);
    int pat = int'(s[4:1]);
    int rsv = int'(s[0] | s[18] | (|s[LEN-1:20]));
    int err = (rsv != 0 || pat > 8 || ratio == 7 || wm == 1) ? 1 : 0;
    chk("R5 pattern", int'(pattern_code), pat);
    chk("R6 multiplier", int'(clk_mult), (ratio == 7) ? 0 : ratio + 2);
    chk("R7 endian", int'(big_endian), int'(s[8]));
    chk("R7 bus width", int'(bus_32), int'(s[12]));
    chk("R8 write mode", int'(wr_mode), wm);
    chk("R9 timer enable", int'(timer_irq_en), 1 - int'(s[11]));
    chk("R9 fast multiply", int'(fast_mult_en), 1 - int'(s[19]));
    chk("R10 drive", int'(drive_pct), exp_drive(int'(s[14:13])));
    chk("R11 delay", int'(addr_data_dly), int'(s[17:15]));
    chk("R12 error", int'(mode_error), err);
  endtask

  task automatic run_load(input logic [LEN-1:0] s);
    logic [31:0] snap;
    rst_n = 1'b0;
    serial_in = s[0];
    repeat (2) @(negedge clk);
    chk("R3 done in reset", int'(done), 0);
    chk("R1 mode_clk in reset", int'(mode_clk), 0);
    chk("R12 error in reset", int'(mode_error), 0);
    rst_n = 1'b1;
    for (int k = 1; k < LEN; k++) begin
      @(negedge mode_clk);
      @(negedge clk);
      if (k == LEN - 1) begin
        chk("R3 done early", int'(done), 0);
        chk("R12 error before done", int'(mode_error), 0);
      end
      serial_in = s[k];
    end
    @(negedge mode_clk);
    @(negedge clk);
    chk("R3 done after last period", int'(done), 1);
    chk("R1 period", per_meas, DIV);
    chk("R1 high time", hi_meas, DIV / 2);
    // R2: correct bit order shows up in every decoded field
    check_fields(s);
    snap = {pattern_code, clk_mult, big_endian, wr_mode, timer_irq_en, bus_32,
            drive_pct, addr_data_dly, fast_mult_en, mode_error};
    for (int j = 0; j < 3 * DIV; j++) begin
      @(negedge clk);
      serial_in = ~serial_in;
      if (mode_clk) chk("R1 mode_clk idle after done", 1, 0);
    end
    @(negedge clk);
    chk("R4 frozen outputs", int'({pattern_code, clk_mult, big_endian, wr_mode,
        timer_irq_en, bus_32, drive_pct, addr_data_dly, fast_mult_en, mode_error}),
        int'(snap));
    chk("R3 done held", int'(done), 1);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rpos[8] = '{0, 18, 20, 23, 25, 26, 27, 31};
    logic [LEN-1:0] s;
    // all-zero stream is legal
    run_load('0);
    // sweep of field codes, legal and reserved mixed
    for (int i = 0; i < 64; i++) begin
      run_load(mk(i % 16, i % 8, i % 2, (i / 2) % 4, (i / 3) % 2, (i / 4) % 2,
                  (i / 5) % 4, (i / 7) % 8, (i / 9) % 2));
    end
    // R12: each reserved bit alone, other fields legal
    for (int r = 0; r < 8; r++) begin
      s = mk(3, 2, 1, 2, 0, 1, 2, 5, 1);
      s[rpos[r]] = 1'b1;
      run_load(s);
    end
    // R2: single one walking through the decoded region
    for (int b = 1; b < 20; b++) begin
      if (b != 18) begin
        s = '0;
        s[b] = 1'b1;
        run_load(s);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule